// File: doc/BRIEF.md
# Software/Hardware Clock Gate Controller

This block controls one clock enable. Software can own the gate and drive it from an enable bit, or hand it to a hardware request input. A read-only status bit reports the real gate state through a two-stage synchroniser, so software can poll it until it agrees with the requested value. An optional turn-off hysteresis keeps the gate open for a short or a long number of cycles after the request drops. A new request during that window cancels the pending turn-off.

The control and hysteresis registers are write-protected. A key written to the access register at offset 0x0 opens them, and the same key with bit 0 clear closes them again. While the registers are locked, writes to them are silently dropped. Reads are always allowed. The register bus is a simple single-cycle write strobe with a combinational read port. The gated output is a clock-enable level for a downstream clock gate cell.

Top module: `clk_gate_ctrl`

## Requirements
- R1: A write to offset 0x0 whose bits [31:1] equal 0x52D280 (the value 0xA5A500 with bit 0 as the lock control) sets the unlock state to bit 0 of the written data. A write to offset 0x0 with any other upper bits leaves the unlock state unchanged. Reading offset 0x0 returns the unlock state in bit 0 and zero in every other bit.
- R2: While the block is locked, writes to the control register (0x4) and the hysteresis register (0x8) are dropped. Both registers can always be read.
- R3: The control register at 0x4 holds the enable bit in bit 0 and the owner bit in bit 1 (1 = software owns the gate). When software owns the gate, clk_en_o follows the enable bit one clock after the register write.
- R4: When the owner bit is 0, clk_en_o follows hw_req_i one clock later, and the software enable bit has no effect.
- R5: Bit 2 of the control register is read-only. It equals clk_en_o delayed by exactly two clocks, on both rising and falling transitions.
- R6: With parameter NO_DISABLE=1, a gate owned by software stays on while its enable bit is 0.
- R7: With hysteresis disabled (0x8 bit 0 = 0), the gate closes on the first clock edge at which the request is sampled low.
- R8: With hysteresis enabled, the gate closes on the D-th consecutive clock edge at which the request is low. D is HYST_SHORT (default 8) when 0x8 bit 1 is 0, and HYST_LONG (default 64) when that bit is 1.
- R9: A request sampled high during the hysteresis window keeps the gate open and restarts the full window.
- R10: After reset the block is locked, the owner bit is 1, the enable bit is 0, hysteresis is off, and clk_en_o and the status bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| hw_req_i | input | 1 | Hardware gate request |
| clk_en_o | output | 1 | Gated clock enable |

## Verification
The bench builds two instances that share one bus and one request input. The first uses NO_DISABLE=0. The second uses NO_DISABLE=1, which brings the forced-on behaviour within reach at the same moments the first instance closes. Both use the default delays of 8 and 64 cycles, so a single table walk can drive the request low for exactly D-1 and D edges. This covers the off-by-one boundary of each hysteresis setting, and the long window still stays short enough to run.

// File: rtl/cgc_pkg.sv
`timescale 1ns/1ps
package cgc_pkg;
  localparam logic [30:0] ACCESS_KEY = 31'h0052_D280;
  localparam int unsigned OFF_ACCESS = 0;
  localparam int unsigned OFF_CTRL   = 4;
  localparam int unsigned OFF_HYST   = 8;

  typedef struct packed {
    logic own_sw;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic long_dly;
    logic en;
  } hyst_t;
endpackage

// File: rtl/cgc_regs.sv
`timescale 1ns/1ps
module cgc_regs import cgc_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              status_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o,
  output hyst_t             hyst_o
);
  logic  unlock_q;
  ctrl_t ctrl_q;
  hyst_t hyst_q;
  logic  sel_acc, sel_ctrl, sel_hyst, key_ok;
  logic  unused_wdata;

  assign sel_acc  = addr_i == ADDR_W'(OFF_ACCESS);
  assign sel_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_hyst = addr_i == ADDR_W'(OFF_HYST);
  assign key_ok   = wdata_i[31:1] == ACCESS_KEY;
  assign unused_wdata = ^wdata_i[31:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      ctrl_q   <= '{own_sw: 1'b1, en: 1'b0};
      hyst_q   <= '0;
    end else if (wr_i) begin
      if (sel_acc && key_ok) unlock_q <= wdata_i[0];
      if (sel_ctrl && unlock_q) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      if (sel_hyst && unlock_q) hyst_q <= hyst_t'(wdata_i[1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_acc)  rdata_o[0]   = unlock_q;
    if (sel_ctrl) rdata_o[2:0] = {status_i, ctrl_q};
    if (sel_hyst) rdata_o[1:0] = hyst_q;
  end

  assign ctrl_o = ctrl_q;
  assign hyst_o = hyst_q;

  // R2: locked writes leave protected state untouched
  a_r2_locked_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !unlock_q && !sel_acc) |=> ($stable(ctrl_q) && $stable(hyst_q)));
  // R1: a wrong key never moves the lock
  a_r1_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_acc && !key_ok) |=> $stable(unlock_q));
endmodule

// File: rtl/cgc_gate.sv
`timescale 1ns/1ps
module cgc_gate import cgc_pkg::*; #(
  parameter int unsigned HYST_SHORT = 8,
  parameter int unsigned HYST_LONG  = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  hyst_t hyst_i,
  output logic  gate_o
);
  localparam int unsigned CNT_W = $clog2(HYST_LONG + 1);

  logic             gate_q;
  logic [CNT_W-1:0] cnt_q, dly;
  logic             expire;

  always_comb begin
    if (!hyst_i.en)           dly = CNT_W'(1);
    else if (hyst_i.long_dly) dly = CNT_W'(HYST_LONG);
    else                      dly = CNT_W'(HYST_SHORT);
  end

  // >= tolerates a delay setting shrunk mid-window
  assign expire = ({1'b0, cnt_q} + 1'b1) >= {1'b0, dly};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (req_i) begin
      gate_q <= 1'b1;
      cnt_q  <= '0;
    end else if (gate_q) begin
      if (expire) begin
        gate_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gate_o = gate_q;

  // R9: a request always holds or reopens the gate
  a_r9_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> gate_q);
  // R7: no hysteresis means close on first low edge
  a_r7_fast_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && gate_q && !hyst_i.en) |=> !gate_q);
  // R8: window counter is idle whenever the gate is closed
  a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_q |-> (cnt_q == '0));
endmodule

// File: rtl/cgc_sync.sv
`timescale 1ns/1ps
module cgc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

  // R5: status lags the gate by exactly STAGES clocks
  a_r5_status_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == $past(d_i, STAGES));
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl import cgc_pkg::*; #(
  parameter int unsigned ADDR_W     = 8,
  parameter bit          NO_DISABLE = 1'b0,
  parameter int unsigned HYST_SHORT = 8,
  parameter int unsigned HYST_LONG  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              hw_req_i,
  output logic              clk_en_o
);
  localparam int unsigned SYNC_STAGES = 2;

  ctrl_t ctrl;
  hyst_t hyst;
  logic  status, req, gate;

  cgc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status),
    .rdata_o  (reg_rdata_o),
    .ctrl_o   (ctrl),
    .hyst_o   (hyst)
  );

  assign req = ctrl.own_sw ? (ctrl.en | NO_DISABLE) : hw_req_i;

  cgc_gate #(.HYST_SHORT(HYST_SHORT), .HYST_LONG(HYST_LONG)) u_gate (
    .clk_i, .rst_ni,
    .req_i  (req),
    .hyst_i (hyst),
    .gate_o (gate)
  );

  cgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i (gate),
    .q_o (status)
  );

  assign clk_en_o = gate;

  // R3: software-owned gate opens one clock after enable
  a_r3_sw_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.own_sw && (ctrl.en || NO_DISABLE)) |=> clk_en_o);
  // R4: hardware-owned gate opens one clock after request
  a_r4_hw_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.own_sw && hw_req_i) |=> clk_en_o);
  // R6: no-disable gate under software is never closed
  a_r6_no_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NO_DISABLE && ctrl.own_sw) |=> clk_en_o);
endmodule

// File: tb/clk_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_gate_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        hw_req = 1'b0;
  logic [31:0] rdata, rdata_nd;
  logic        en_o, en_nd;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  clk_gate_ctrl #(.NO_DISABLE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hw_req_i(hw_req), .clk_en_o(en_o));

  clk_gate_ctrl #(.NO_DISABLE(1'b1)) dut_nd_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_nd), .hw_req_i(hw_req), .clk_en_o(en_nd));

  // {hyst_en, long, low_edges, expected clk_en_o}
  localparam logic [9:0] VEC [7] = '{
    {1'b0, 1'b0, 7'd1,  1'b0},
    {1'b0, 1'b1, 7'd1,  1'b0},
    {1'b1, 1'b0, 7'd7,  1'b1},
    {1'b1, 1'b0, 7'd8,  1'b0},
    {1'b1, 1'b1, 7'd63, 1'b1},
    {1'b1, 1'b1, 7'd64, 1'b0},
    {1'b1, 1'b0, 7'd20, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 clk_en", {31'b0, en_o}, 32'h0);
    rd_reg(8'h0, r); check("R10 access", r, 32'h0);
    rd_reg(8'h4, r); check("R10 ctrl", r, 32'h2);
    rd_reg(8'h8, r); check("R10 hyst", r, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 nodisable on after reset", {31'b0, en_nd}, 32'h1);
    check("R10 gate stays off", {31'b0, en_o}, 32'h0);

    // R2 locked writes dropped
    wr_reg(8'h4, 32'h3);
    wr_reg(8'h8, 32'h3);
    rd_reg(8'h4, r); check("R2 ctrl locked", r, 32'h2);
    rd_reg(8'h8, r); check("R2 hyst locked", r, 32'h0);
    check("R2 gate off", {31'b0, en_o}, 32'h0);

    // R1 key handling
    wr_reg(8'h0, 32'h00A5_A401);
    rd_reg(8'h0, r); check("R1 wrong key", r, 32'h0);
    wr_reg(8'h0, 32'h00A5_A501);
    rd_reg(8'h0, r); check("R1 unlock", r, 32'h1);

    // R3 / R5 software on
    wr_reg(8'h4, 32'h3);
    check("R3 no change at write edge", {31'b0, en_o}, 32'h0);
    @(negedge clk);
    check("R3 on one clock later", {31'b0, en_o}, 32'h1);
    rd_reg(8'h4, r); check("R5 status still low", r, 32'h3);
    @(negedge clk);
    rd_reg(8'h4, r); check("R5 status low after one", r, 32'h3);
    @(negedge clk);
    rd_reg(8'h4, r); check("R5 status high after two", r, 32'h7);

    // R3 / R5 / R6 software off
    wr_reg(8'h4, 32'h2);
    @(negedge clk);
    check("R3 off one clock later", {31'b0, en_o}, 32'h0);
    check("R6 nodisable ignores en=0", {31'b0, en_nd}, 32'h1);
    @(negedge clk);
    rd_reg(8'h4, r); check("R5 status falls late", r, 32'h6);
    @(negedge clk);
    rd_reg(8'h4, r); check("R5 status falls", r, 32'h2);

    // R4 hardware owner, software enable ignored
    wr_reg(8'h4, 32'h1);
    repeat (3) @(negedge clk);
    check("R4 en bit no effect", {31'b0, en_o}, 32'h0);
    hw_req = 1'b1;
    @(negedge clk);
    check("R4 follows request", {31'b0, en_o}, 32'h1);
    check("R4 nodisable follows request", {31'b0, en_nd}, 32'h1);

    // R7 / R8 vector walk
    foreach (VEC[i]) begin
      wr_reg(8'h8, {30'b0, VEC[i][8], VEC[i][9]});
      hw_req = 1'b1;
      repeat (2) @(negedge clk);
      hw_req = 1'b0;
      repeat (int'(VEC[i][7:1])) @(negedge clk);
      check(VEC[i][9] ? "R8 hysteresis window" : "R7 immediate off",
            {31'b0, en_o}, {31'b0, VEC[i][0]});
      hw_req = 1'b1;
      repeat (2) @(negedge clk);
    end

    // R9 cancel and restart
    wr_reg(8'h8, 32'h1);
    hw_req = 1'b0; repeat (5) @(negedge clk);
    hw_req = 1'b1; @(negedge clk);
    hw_req = 1'b0; repeat (7) @(negedge clk);
    check("R9 window restarted", {31'b0, en_o}, 32'h1);
    @(negedge clk);
    check("R9 closes after full window", {31'b0, en_o}, 32'h0);

    // R1 relock then R2 drop
    wr_reg(8'h0, 32'h00A5_A500);
    rd_reg(8'h0, r); check("R1 relock", r, 32'h0);
    wr_reg(8'h4, 32'h3);
    rd_reg(8'h4, r); check("R2 write dropped after relock", r, 32'h1);
    repeat (2) @(negedge clk);
    check("R2 gate unchanged", {31'b0, en_o}, 32'h0);

    finish_run();
  end
endmodule